// File: doc/BRIEF.md
# Grouped Sample-Strobe Divider

This block turns rate-generator ticks into per-channel sample strobes for six converter channels, arranged as two groups of three. Each group picks its own tick source: one of two internal rate generators or an external clock input. The generators and the external clock are all given to the block as single-cycle tick enables in the system clock domain. The chosen ticks pass through a group prescaler that divides by 32 or by 64, depending on the oversampling mode. Each channel then divides the prescaled rate by its own integer ratio from 1 to 20. Channels in one group therefore run at rates that are harmonically related.

A group is realigned by a sync event, which is either a software sync bit or the external sync pulse gated by a per-group enable. A sync event clears the prescaler and every channel divider in that group in the same cycle. It also loads the channel ratios, so a new ratio takes effect only at a sync. A registered clock-out tick repeats one selectable source so that further units can be chained. A settle timer starts again on any change to the source selection, the mode or the ratios. When it expires it can raise a one-cycle interrupt pulse.

Top module: `sclk_divider_top`

## Requirements
- R1: After reset all strobes, the clock-out tick and the settle interrupt are low. Every channel runs at ratio 1 until its group's first sync. The prescaler starts counting from zero when reset is released.
- R2: Group g's two bits in `grp_src_sel` choose its tick source: 0 selects `gen_tick[0]`, 1 selects `gen_tick[1]`, and 2 or 3 select `ext_tick`. A group whose selected source never ticks never strobes.
- R3: The prescale factor P is 32 when `os_x32` is 0 and 64 when it is 1. After a sync event, every channel in the group strobes once on the P-th source tick. The strobe is visible one cycle after the edge that registers that tick.
- R4: A channel whose ratio r lies between 1 and 20 strobes every r*P source ticks after its first strobe. Each strobe lasts one cycle.
- R5: A ratio field of 0 acts as 1, and a ratio above 20 acts as 20. Channel c takes its ratio from `chan_ratio[5c+4:5c]`, and channels 0 to 2 form group 0.
- R6: A change to a channel's ratio field has no effect on its strobe spacing until the next sync event of its group.
- R7: A sync event for group g is `sw_sync[g]`, or `ext_sync` while `ext_sync_en[g]` is 1. It clears the group's prescaler and dividers and discards that cycle's source tick. No strobe of the group appears in the following cycle, and the other group keeps its phase.
- R8: `clk_out_tick` is the value, one cycle earlier, of the source chosen by `clkout_sel`: 1 selects `gen_tick[0]`, 2 selects `gen_tick[1]`, and 0 or 3 select `ext_tick`.
- R9: A change to `grp_src_sel`, `os_x32` or `chan_ratio` loads the settle timer with `settle_len`, and a length of 0 acts as 1. When the timer is loaded with L in the cycle after edge E0, the interrupt pulses for one cycle after edge E0+L. A further change restarts the count.
- R10: While `settle_irq_en` is 0, the expiry of the settle timer produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| gen_tick | input | 2 | tick enables of the two internal rate generators |
| ext_tick | input | 1 | external clock tick enable |
| ext_sync | input | 1 | external sync pulse |
| os_x32 | input | 1 | oversampling mode: 0 prescales by 32, 1 by 64 |
| grp_src_sel | input | 4 | two-bit tick source choice per group |
| chan_ratio | input | 30 | five-bit divide ratio per channel |
| sw_sync | input | 2 | software sync, one bit per group |
| ext_sync_en | input | 2 | per-group enable for the external sync |
| clkout_sel | input | 2 | source of the chained clock-out tick |
| settle_len | input | 16 | settle interval in cycles |
| settle_irq_en | input | 1 | enables the settle interrupt pulse |
| sample_strobe | output | 6 | per-channel sample strobes |
| clk_out_tick | output | 1 | registered clock-out tick for chaining |
| settle_irq | output | 1 | one-cycle settle-complete pulse |

## Verification
The assertions assume that a sync request and a source tick are single-cycle events sampled on the system clock. They also assume that reset is held for at least one edge before any $past comparison counts. The checks on ratio holding and on the quiet cycle after a sync take it as given that configuration changes and sync pulses arrive only at clock edges. The stimulus changes every input half a cycle away from the active edge, and it raises each sync for exactly one cycle. The stimulus waits out each settle count before it starts a new interrupt check, so leftover expiries from earlier configuration changes cannot leak into that check.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // tick source chosen per group
    typedef enum logic [1:0] {
        SRC_GEN0    = 2'd0,
        SRC_GEN1    = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_EXT_ALT = 2'd3
    } src_sel_e;

    // source repeated on the chained clock-out tick
    typedef enum logic [1:0] {
        CKO_EXT     = 2'd0,
        CKO_GEN0    = 2'd1,
        CKO_GEN1    = 2'd2,
        CKO_EXT_ALT = 2'd3
    } cko_sel_e;

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int PRE_SMALL = 32,
    parameter int PRE_LARGE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_tick,
    input  logic sync,
    input  logic os_x32,
    output logic pre_tick
);
    localparam int PRE_W = $clog2(PRE_LARGE);
    localparam logic [PRE_W-1:0] LAST_S = PRE_W'(PRE_SMALL - 1);
    localparam logic [PRE_W-1:0] LAST_L = PRE_W'(PRE_LARGE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] last;
    logic at_last;

    always_comb begin
        last     = os_x32 ? LAST_L : LAST_S;
        at_last  = (st_q.cnt >= last);
        pre_tick = src_tick && !sync && at_last;
        st_d     = st_q;
        if (sync) begin
            st_d.cnt = '0;
        end else if (src_tick) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a sync leaves the prescaler at its start phase
    p_sync_clears_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (st_q.cnt == '0));

endmodule

// File: rtl/sclk_chan_div.sv
module sclk_chan_div #(
    parameter int RATIO_W   = 5,
    parameter int MAX_RATIO = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync,
    input  logic               pre_tick,
    input  logic [RATIO_W-1:0] ratio_cfg,
    output logic               strobe
);
    typedef struct packed {
        logic [RATIO_W-1:0] ratio_act;
        logic [RATIO_W-1:0] cnt;
        logic               strobe;
    } div_state_t;

    div_state_t st_d, st_q;

    function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
        if (r == '0)                          return RATIO_W'(1);
        else if (r > RATIO_W'(MAX_RATIO))     return RATIO_W'(MAX_RATIO);
        else                                  return r;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (sync) begin
            st_d.ratio_act = clamp_ratio(ratio_cfg);
            st_d.cnt       = '0;
        end else if (pre_tick) begin
            st_d.strobe = (st_q.cnt == '0);
            st_d.cnt    = (st_q.cnt >= st_q.ratio_act - RATIO_W'(1)) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ratio_act <= RATIO_W'(1);
            st_q.cnt       <= '0;
            st_q.strobe    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    // R5: the ratio in use stays within 1..MAX_RATIO
    p_ratio_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ratio_act != '0) && (st_q.ratio_act <= RATIO_W'(MAX_RATIO)));

    // R4: the phase counter stays below the ratio in use
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.ratio_act);

    // R6: the ratio in use changes only at a sync
    p_ratio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(st_q.ratio_act));

    // R7: no strobe in the cycle after a sync
    p_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !strobe);

    // R3: a strobe needs a prescaler output in the cycle before
    p_strobe_from_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(rst_n)) |-> $past(pre_tick));

endmodule

// File: rtl/sclk_settle.sv
module sclk_settle #(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_change,
    input  logic [SETTLE_W-1:0] len,
    input  logic                irq_en,
    output logic                irq
);
    typedef struct packed {
        logic [SETTLE_W-1:0] cnt;
        logic                irq;
    } settle_state_t;

    settle_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cfg_change) begin
            st_d.cnt = (len == '0) ? SETTLE_W'(1) : len;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.irq = (st_q.cnt == SETTLE_W'(1)) && irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R9: a pulse only follows a count of one
    p_settle_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rst_n)) |-> ($past(st_q.cnt) == SETTLE_W'(1)));

    // R10: a pulse needs the enable in the cycle before
    p_settle_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rst_n)) |-> $past(irq_en));

endmodule

// File: rtl/sclk_divider_top.sv
module sclk_divider_top
    import sclk_pkg::*;
#(
    parameter int NUM_GRP    = 2,
    parameter int CH_PER_GRP = 3,
    parameter int RATIO_W    = 5,
    parameter int MAX_RATIO  = 20,
    parameter int PRE_SMALL  = 32,
    parameter int PRE_LARGE  = 64,
    parameter int SETTLE_W   = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [1:0]                             gen_tick,
    input  logic                                   ext_tick,
    input  logic                                   ext_sync,
    input  logic                                   os_x32,
    input  logic [2*NUM_GRP-1:0]                   grp_src_sel,
    input  logic [RATIO_W*NUM_GRP*CH_PER_GRP-1:0]  chan_ratio,
    input  logic [NUM_GRP-1:0]                     sw_sync,
    input  logic [NUM_GRP-1:0]                     ext_sync_en,
    input  logic [1:0]                             clkout_sel,
    input  logic [SETTLE_W-1:0]                    settle_len,
    input  logic                                   settle_irq_en,
    output logic [NUM_GRP*CH_PER_GRP-1:0]          sample_strobe,
    output logic                                   clk_out_tick,
    output logic                                   settle_irq
);
    localparam int NUM_CH = NUM_GRP * CH_PER_GRP;
    localparam int SRC_W  = 2;

    typedef struct packed {
        logic [SRC_W*NUM_GRP-1:0]  src_prev;
        logic [RATIO_W*NUM_CH-1:0] ratio_prev;
        logic                      os_prev;
        logic                      clk_out;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [NUM_GRP-1:0] grp_tick;
    logic [NUM_GRP-1:0] grp_sync;
    logic [NUM_GRP-1:0] pre_tick;
    logic               cfg_change;

    // per-group source choice and sync event
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            case (src_sel_e'(grp_src_sel[SRC_W*g +: SRC_W]))
                SRC_GEN0: grp_tick[g] = gen_tick[0];
                SRC_GEN1: grp_tick[g] = gen_tick[1];
                default:  grp_tick[g] = ext_tick;
            endcase
            grp_sync[g] = sw_sync[g] | (ext_sync & ext_sync_en[g]);
        end
    end

    always_comb begin
        st_d            = st_q;
        st_d.src_prev   = grp_src_sel;
        st_d.ratio_prev = chan_ratio;
        st_d.os_prev    = os_x32;
        cfg_change      = (grp_src_sel != st_q.src_prev) ||
                          (chan_ratio  != st_q.ratio_prev) ||
                          (os_x32      != st_q.os_prev);
        case (cko_sel_e'(clkout_sel))
            CKO_GEN0: st_d.clk_out = gen_tick[0];
            CKO_GEN1: st_d.clk_out = gen_tick[1];
            default:  st_d.clk_out = ext_tick;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out_tick = st_q.clk_out;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        sclk_prescale #(
            .PRE_SMALL (PRE_SMALL),
            .PRE_LARGE (PRE_LARGE)
        ) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (grp_tick[g]),
            .sync     (grp_sync[g]),
            .os_x32   (os_x32),
            .pre_tick (pre_tick[g])
        );

        for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_ch
            localparam int CH = g * CH_PER_GRP + c;
            sclk_chan_div #(
                .RATIO_W   (RATIO_W),
                .MAX_RATIO (MAX_RATIO)
            ) u_div (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync      (grp_sync[g]),
                .pre_tick  (pre_tick[g]),
                .ratio_cfg (chan_ratio[RATIO_W*CH +: RATIO_W]),
                .strobe    (sample_strobe[CH])
            );
        end

        // R2: a group strobes only after a tick of its chosen source
        p_strobe_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ((|sample_strobe[g*CH_PER_GRP +: CH_PER_GRP]) && $past(rst_n)) |-> $past(grp_tick[g]));
    end

    sclk_settle #(
        .SETTLE_W (SETTLE_W)
    ) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_change (cfg_change),
        .len        (settle_len),
        .irq_en     (settle_irq_en),
        .irq        (settle_irq)
    );

    // R8: clock-out repeats generator 0 one cycle later when chosen
    p_clkout_gen0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(clkout_sel) == 2'd1)) |-> (clk_out_tick == $past(gen_tick[0])));

endmodule

// File: tb/tb_sclk_divider_top.sv
module tb_sclk_divider_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  gen_tick;
    logic        ext_tick, ext_sync, os_x32;
    logic [3:0]  grp_src_sel;
    logic [29:0] chan_ratio;
    logic [1:0]  sw_sync, ext_sync_en, clkout_sel;
    logic [15:0] settle_len;
    logic        settle_irq_en;
    logic [5:0]  sample_strobe;
    logic        clk_out_tick, settle_irq;

    sclk_divider_top dut (
        .clk(clk), .rst_n(rst_n), .gen_tick(gen_tick), .ext_tick(ext_tick),
        .ext_sync(ext_sync), .os_x32(os_x32), .grp_src_sel(grp_src_sel),
        .chan_ratio(chan_ratio), .sw_sync(sw_sync), .ext_sync_en(ext_sync_en),
        .clkout_sel(clkout_sel), .settle_len(settle_len), .settle_irq_en(settle_irq_en),
        .sample_strobe(sample_strobe), .clk_out_tick(clk_out_tick), .settle_irq(settle_irq)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int first_t[6];
    int second_t[6];
    int irq_t, irq_n;

    // monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        for (int ch = 0; ch < 6; ch++) begin
            if (sample_strobe[ch]) begin
                if (first_t[ch] < 0)       first_t[ch] = cyc;
                else if (second_t[ch] < 0) second_t[ch] = cyc;
            end
        end
        if (settle_irq) begin
            irq_n++;
            if (irq_t < 0) irq_t = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampr(input int r);
        if (r == 0) return 1;
        if (r > 20) return 20;
        return r;
    endfunction

    task automatic clear_grp(input int g);
        for (int c = 0; c < 3; c++) begin
            first_t[g*3+c]  = -1;
            second_t[g*3+c] = -1;
        end
    endtask

    task automatic clear_mon();
        clear_grp(0);
        clear_grp(1);
        irq_t = -1;
        irq_n = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sync(input logic [1:0] m, output int t0);
        @(negedge clk);
        sw_sync = m;
        @(negedge clk);
        sw_sync = 2'b00;
        t0 = cyc;
        clear_mon();
    endtask

    task automatic set_all_ratios(input int r);
        for (int ch = 0; ch < 6; ch++) chan_ratio[5*ch +: 5] = 5'(r);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int t0, t1, p, r, sel_v, exp_v;
        clear_mon();
        rst_n = 1'b0;
        gen_tick = 2'b11; ext_tick = 1'b0; ext_sync = 1'b0; os_x32 = 1'b0;
        grp_src_sel = 4'b0000; sw_sync = 2'b00; ext_sync_en = 2'b00;
        clkout_sel = 2'd0; settle_len = 16'd10; settle_irq_en = 1'b0;
        set_all_ratios(5);
        wait_cyc(4);
        // R1: reset state
        chk("R1 strobes", int'(sample_strobe), 0);
        chk("R1 clkout", int'(clk_out_tick), 0);
        chk("R1 irq", int'(settle_irq), 0);
        rst_n = 1'b1;
        t0 = cyc;
        clear_mon();
        wait_cyc(32 * 2 + 4);
        // R1: ratio 1 in force before the first sync, prescaler from zero
        chk("R1 first", first_t[0], t0 + 32);
        chk("R1 second", second_t[0], t0 + 64);
        chk("R1 first g1", first_t[4], t0 + 32);

        // R3 R4 R5: sweep of ratio codes and both modes
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            os_x32 = v[0];
            p = v[0] ? 64 : 32;
            for (int ch = 0; ch < 6; ch++) chan_ratio[5*ch +: 5] = 5'((v + 7*ch) % 32);
            do_sync(2'b11, t0);
            wait_cyc(p * 21 + 3);
            for (int ch = 0; ch < 6; ch++) begin
                r = (v + 7*ch) % 32;
                chk("R3 first strobe", first_t[ch], t0 + p);
                if (r >= 1 && r <= 20) chk("R4 spacing", second_t[ch], t0 + p + p * r);
                else                   chk("R5 clamped spacing", second_t[ch], t0 + p + p * clampr(r));
            end
        end

        // R6: ratio change waits for a sync
        @(negedge clk);
        os_x32 = 1'b0;
        set_all_ratios(2);
        do_sync(2'b11, t0);
        wait_cyc(10);
        set_all_ratios(5);
        wait_cyc(10);
        clear_mon();
        wait_cyc(200);
        chk("R6 held ch0", second_t[0] - first_t[0], 64);
        chk("R6 held ch3", second_t[3] - first_t[3], 64);
        do_sync(2'b11, t0);
        wait_cyc(32 * 6 + 4);
        chk("R6 applied ch0", second_t[0], t0 + 32 + 160);
        chk("R6 applied ch5", second_t[5], t0 + 32 + 160);

        // R7: external sync reaches only the enabled group
        set_all_ratios(1);
        do_sync(2'b10, t1);
        wait_cyc(5);
        ext_sync_en = 2'b01;
        ext_sync = 1'b1;
        @(negedge clk);
        ext_sync = 1'b0;
        t0 = cyc;
        clear_grp(0);
        wait_cyc(40);
        for (int c = 0; c < 3; c++) begin
            chk("R7 group0 realigned", first_t[c], t0 + 32);
            chk("R7 group1 kept phase", first_t[3 + c], t1 + 32);
        end
        ext_sync_en = 2'b00;

        // R2: source selection
        @(negedge clk);
        gen_tick = 2'b01;
        grp_src_sel = 4'b0001;   // group0 from gen1 (idle), group1 from gen0
        do_sync(2'b11, t0);
        wait_cyc(100);
        chk("R2 idle source g0", first_t[0], -1);
        chk("R2 gen0 source g1", first_t[3], t0 + 32);
        @(negedge clk);
        gen_tick = 2'b00;
        ext_tick = 1'b1;
        grp_src_sel = 4'b0010;   // group0 from ext, group1 from gen0 (idle)
        do_sync(2'b11, t0);
        wait_cyc(100);
        chk("R2 ext source g0", first_t[1], t0 + 32);
        chk("R2 idle source g1", first_t[4], -1);
        @(negedge clk);
        gen_tick = 2'b11;
        ext_tick = 1'b0;
        grp_src_sel = 4'b0000;
        wait_cyc(30);

        // R9 R10: settle timer
        settle_irq_en = 1'b1;
        wait_cyc(30);
        clear_mon();
        os_x32 = ~os_x32;
        @(negedge clk);
        t0 = cyc;
        wait_cyc(20);
        chk("R9 expiry time", irq_t, t0 + 10);
        chk("R9 single pulse", irq_n, 1);
        clear_mon();
        os_x32 = ~os_x32;
        wait_cyc(4);
        chan_ratio[4:0] = 5'd7;
        @(negedge clk);
        t0 = cyc;
        wait_cyc(20);
        chk("R9 restart time", irq_t, t0 + 10);
        chk("R9 restart single", irq_n, 1);
        settle_len = 16'd0;
        clear_mon();
        grp_src_sel = 4'b0100;
        @(negedge clk);
        t0 = cyc;
        wait_cyc(10);
        chk("R9 zero length", irq_t, t0 + 1);
        settle_len = 16'd10;
        settle_irq_en = 1'b0;
        clear_mon();
        grp_src_sel = 4'b0000;
        wait_cyc(25);
        chk("R10 masked", irq_n, 0);

        // R8: clock-out source sweep
        for (int s = 0; s < 4; s++) begin
            for (int pat = 0; pat < 8; pat++) begin
                @(negedge clk);
                clkout_sel = 2'(s);
                gen_tick = 2'(pat & 3);
                ext_tick = pat[2];
                sel_v = s;
                exp_v = (sel_v == 1) ? (pat & 1) : (sel_v == 2) ? ((pat >> 1) & 1) : ((pat >> 2) & 1);
                @(negedge clk);
                chk("R8 clkout", int'(clk_out_tick), exp_v);
            end
        end

        finish_run();
    end
endmodule